// File: doc/BRIEF.md
# Multicycle Multiply/Divide Unit

This unit performs the multiply and divide operations of an 8-bit accumulator machine. It works on three registers: the accumulator (ACC), B and C. The 16-bit source value is the pair ACC:C, and B is the second operand. A multiply produces a 24-bit product that is spread over all three registers. A divide returns a 16-bit quotient in ACC:C and an 8-bit remainder in B.

The surrounding core starts an operation with a one-cycle start pulse. In the same cycle it presents the operation select and the current register values. A fixed number of cycles later the unit returns the new register values, the overflow flag and a strobe telling the core to clear its carry flag. It also raises a one-cycle done pulse. The core keeps its own register file and its own decoder. The unit captures its inputs when it accepts the start pulse and keeps its outputs until the next completion.

Top module: `muldiv_unit`

## Requirements
- R1: The 16-bit source value is {acc_i, c_i}: acc_i is the high byte and c_i is the low byte. All three inputs are captured on the rising edge that accepts start_i. Later changes to them have no effect on the running operation.
- R2: With op_i = 0 (multiply), the 24-bit product {acc_i, c_i} * b_i is returned as b_o = bits 23:16, acc_o = bits 15:8 and c_o = bits 7:0.
- R3: After a multiply, ov_o is 1 when the product is 65536 or more, and 0 otherwise.
- R4: With op_i = 1 (divide) and a nonzero b_i, {acc_o, c_o} is the quotient {acc_i, c_i} / b_i and b_o is the remainder.
- R5: After a divide by a nonzero divisor, ov_o is 1 when the remainder is zero, and 0 otherwise.
- R6: A divide with b_i = 0 returns acc_o = c_o = 8'hFF and leaves b_o at 0. It sets ov_o to 1 and keeps the normal latency.
- R7: cy_clr_o pulses high in the same cycle as done_o, for both operations.
- R8: done_o is high for exactly one cycle. It is high after the 7th rising edge, counting the edge that accepts start_i as the first.
- R9: A start_i pulse that arrives while an operation is running is ignored. It does not change that operation's results or completion time, and it produces no extra done_o.
- R10: While rst_n is low at a rising edge, all outputs are cleared to zero and any running operation is abandoned without a done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start pulse; accepted only when idle |
| op_i | input | 1 | 0 = multiply, 1 = divide |
| acc_i | input | 8 | Accumulator value (high byte of the source) |
| b_i | input | 8 | B register value (multiplier or divisor) |
| c_i | input | 8 | C register value (low byte of the source) |
| acc_o | output | 8 | New accumulator value |
| b_o | output | 8 | New B value |
| c_o | output | 8 | New C value |
| ov_o | output | 1 | Overflow flag result |
| cy_clr_o | output | 1 | Strobe to clear the carry flag |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions rely on three things about the inputs:
- start_i is only meaningful as a pulse.
- The op select and operands are valid in the cycle the pulse is accepted.
- The core does not expect a result before done_o.

They do not rely on start_i staying low while the unit is busy. The stimulus drives every input at the falling edge. It holds the operands for exactly the accepting cycle and then scrambles them to expose any late sampling. It also deliberately pulses start_i mid-operation with different operands, so the ignore rule is exercised rather than assumed.

// File: rtl/muldiv_pkg.sv
`timescale 1ns/1ps
// Package: shared sizes and the operation encoding for the multiply/divide unit.
// Assumes an 8-bit register file and the fixed latency of the host core.
package muldiv_pkg;
    localparam int REG_W   = 8;   // width of ACC, B and C
    localparam int LATENCY = 7;   // edges from accept to done, inclusive

    typedef enum logic {
        OP_MUL = 1'b0,
        OP_DIV = 1'b1
    } md_op_e;
endpackage

// File: rtl/muldiv_seq.sv
`timescale 1ns/1ps
// Module: muldiv_seq
// Sequencer. It accepts a start pulse when idle, emits one step per cycle
// for STEPS cycles, flags the last step, and registers the done pulse.
// It assumes start_i is a level sampled on each rising edge. Starts that
// arrive while busy are dropped here.
module muldiv_seq #(
    parameter int LATENCY = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic load_o,
    output logic step_o,
    output logic last_o,
    output logic done_o
);
    localparam int STEPS = LATENCY - 1;
    localparam int CW    = (STEPS > 1) ? $clog2(STEPS) + 1 : 1;

    logic          busy_q;
    logic [CW-1:0] cnt_q;

    // Decode the strobes that drive the engine and the output stage.
    assign load_o = start_i && !busy_q;
    assign step_o = busy_q;
    assign last_o = busy_q && (cnt_q == CW'(STEPS - 1));

    // Track the busy window and count the iteration steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (load_o) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
        end else if (busy_q) begin
            cnt_q <= cnt_q + 1'b1;
            if (last_o) busy_q <= 1'b0;
        end
    end

    // Register the completion pulse one edge after the last step.
    always_ff @(posedge clk) begin
        if (!rst_n) done_o <= 1'b0;
        else        done_o <= last_o;
    end

    // R8: the done pulse lasts a single cycle.
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: the step count never runs past the iteration window.
    p_count_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (cnt_q < CW'(STEPS)));

    // R9: a start seen while busy neither restarts nor stalls the count.
    p_ignore_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && start_i && !last_o) |=> (busy_q && cnt_q == CW'($past(cnt_q) + 1'b1)));
endmodule

// File: rtl/muldiv_engine.sv
`timescale 1ns/1ps
// Module: muldiv_engine
// Iterative datapath. On load it captures the operands. Each step then
// handles RB bits of the zero-padded 16-bit source, MSB first, through RB
// chained stages. Each stage does one shift-add for the product and one
// restoring-divide trial for the quotient/remainder. The next-state values
// are also exported, so that the output stage can capture the result on
// the last step. The outputs are meaningless while B is zero; the output
// stage handles that case.
module muldiv_engine
    import muldiv_pkg::*;
#(
    parameter int DW    = 8,
    parameter int STEPS = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          step_i,
    input  logic          op_i,
    input  logic [DW-1:0] acc_i,
    input  logic [DW-1:0] b_i,
    input  logic [DW-1:0] c_i,
    output md_op_e        op_o,
    output logic [DW-1:0] b_o,
    output logic [3*DW-1:0] prod_nxt_o,
    output logic [2*DW-1:0] quot_nxt_o,
    output logic [DW-1:0] rem_nxt_o
);
    localparam int OPW  = 2 * DW;                    // source width
    localparam int PW   = 3 * DW;                    // product width
    localparam int RB   = (OPW + STEPS - 1) / STEPS; // bits per step
    localparam int PADW = RB * STEPS;                // padded source width

    md_op_e          op_q;
    logic [DW-1:0]   b_q;
    logic [PADW-1:0] opr_q;
    logic [PW-1:0]   prod_q;
    logic [DW-1:0]   rem_q;

    logic [PW-1:0]   pc [0:RB];
    logic [DW-1:0]   rc [0:RB];
    logic [PADW-1:0] oc [0:RB];

    assign pc[0] = prod_q;
    assign rc[0] = rem_q;
    assign oc[0] = opr_q;

    // One multiply and one divide bit per stage, chained RB deep.
    for (genvar g = 0; g < RB; g++) begin : g_stage
        logic          bit_in;
        logic [DW:0]   trial;
        logic          fits;
        assign bit_in   = oc[g][PADW-1];
        assign trial    = {rc[g], bit_in};
        assign fits     = trial >= {1'b0, b_q};
        assign pc[g+1]  = {pc[g][PW-2:0], 1'b0} + (bit_in ? PW'(b_q) : '0);
        assign rc[g+1]  = fits ? DW'(trial - {1'b0, b_q}) : trial[DW-1:0];
        assign oc[g+1]  = {oc[g][PADW-2:0], fits};
    end

    // Capture operands on load and advance the partial results on each step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_MUL;
            b_q    <= '0;
            opr_q  <= '0;
            prod_q <= '0;
            rem_q  <= '0;
        end else if (load_i) begin
            op_q   <= md_op_e'(op_i);
            b_q    <= b_i;
            opr_q  <= PADW'({acc_i, c_i});
            prod_q <= '0;
            rem_q  <= '0;
        end else if (step_i) begin
            opr_q  <= oc[RB];
            prod_q <= pc[RB];
            rem_q  <= rc[RB];
        end
    end

    assign op_o       = op_q;
    assign b_o        = b_q;
    assign prod_nxt_o = pc[RB];
    assign quot_nxt_o = oc[RB][OPW-1:0];
    assign rem_nxt_o  = rc[RB];

    // R4: the partial remainder stays below a nonzero divisor.
    p_rem_below_divisor_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && op_q == OP_DIV && b_q != '0) |-> (rem_q < b_q));
endmodule

// File: rtl/muldiv_unit.sv
`timescale 1ns/1ps
// Module: muldiv_unit (top)
// Multiply and divide of ACC:C against B with a fixed latency. The output
// stage captures the engine's final next-state on the last step. It places
// the product or the quotient/remainder into ACC, B and C, derives the
// overflow flag and applies the divide-by-zero result. It assumes the core
// presents valid operands in the cycle its start pulse is accepted.
module muldiv_unit
    import muldiv_pkg::*;
#(
    parameter int DW      = REG_W,
    parameter int LATENCY = muldiv_pkg::LATENCY
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          op_i,
    input  logic [DW-1:0] acc_i,
    input  logic [DW-1:0] b_i,
    input  logic [DW-1:0] c_i,
    output logic [DW-1:0] acc_o,
    output logic [DW-1:0] b_o,
    output logic [DW-1:0] c_o,
    output logic          ov_o,
    output logic          cy_clr_o,
    output logic          done_o
);
    localparam int STEPS = LATENCY - 1;
    localparam int OPW   = 2 * DW;
    localparam int PW    = 3 * DW;

    logic          load, step, last;
    md_op_e        op_q;
    logic [DW-1:0] b_q;
    logic [PW-1:0] prod_nxt;
    logic [OPW-1:0] quot_nxt;
    logic [DW-1:0] rem_nxt;

    muldiv_seq #(.LATENCY(LATENCY)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .load_o  (load),
        .step_o  (step),
        .last_o  (last),
        .done_o  (done_o)
    );

    muldiv_engine #(.DW(DW), .STEPS(STEPS)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .step_i     (step),
        .op_i       (op_i),
        .acc_i      (acc_i),
        .b_i        (b_i),
        .c_i        (c_i),
        .op_o       (op_q),
        .b_o        (b_q),
        .prod_nxt_o (prod_nxt),
        .quot_nxt_o (quot_nxt),
        .rem_nxt_o  (rem_nxt)
    );

    // Place the final result into the register outputs on the last step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_o    <= '0;
            b_o      <= '0;
            c_o      <= '0;
            ov_o     <= 1'b0;
            cy_clr_o <= 1'b0;
        end else begin
            cy_clr_o <= last;
            if (last) begin
                if (op_q == OP_MUL) begin
                    {b_o, acc_o, c_o} <= prod_nxt;
                    ov_o              <= |prod_nxt[PW-1:OPW];
                end else if (b_q == '0) begin
                    {acc_o, c_o} <= '1;
                    b_o          <= b_q;
                    ov_o         <= 1'b1;
                end else begin
                    {acc_o, c_o} <= quot_nxt;
                    b_o          <= rem_nxt;
                    ov_o         <= (rem_nxt == '0);
                end
            end
        end
    end

    // R3: after a multiply, overflow tracks a nonzero high product byte.
    p_mul_ov_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && op_q == OP_MUL) |-> (ov_o == (b_o != '0)));

    // R5: after a normal divide, overflow tracks a zero remainder.
    p_div_ov_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && op_q == OP_DIV && b_q != '0) |-> (ov_o == (b_o == '0)));

    // R6: a zero divisor yields an all-ones quotient with overflow set.
    p_div_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && op_q == OP_DIV && b_q == '0) |-> (ov_o && acc_o == '1 && c_o == '1 && b_o == '0));

    // R7: the carry-clear strobe only appears alongside done.
    p_cy_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cy_clr_o) |-> done_o);
endmodule

// File: tb/muldiv_unit_test.sv
`timescale 1ns/1ps
// Bench for muldiv_unit: a table of stimulus vectors checked against a
// reference model, followed by directed reset, timing and busy-start tests.
module muldiv_unit_test;
    localparam int DW = 8;
    localparam int NV = 14;

    // Table entries: {op, acc, b, c}; op 0 = multiply, 1 = divide.
    localparam logic [24:0] VECS [NV] = '{
        {1'b0, 8'h00, 8'h00, 8'h00},
        {1'b0, 8'h12, 8'h34, 8'h56},
        {1'b0, 8'hFF, 8'hFF, 8'hFF},
        {1'b0, 8'h00, 8'h01, 8'hFF},
        {1'b0, 8'h80, 8'h02, 8'h00},
        {1'b0, 8'h7F, 8'h02, 8'hFF},
        {1'b0, 8'h01, 8'h01, 8'h00},
        {1'b1, 8'h12, 8'h34, 8'h56},
        {1'b1, 8'hFF, 8'hFF, 8'hFF},
        {1'b1, 8'h00, 8'h07, 8'h05},
        {1'b1, 8'h00, 8'h01, 8'h00},
        {1'b1, 8'hAB, 8'h00, 8'hCD},
        {1'b1, 8'h00, 8'hFF, 8'hFE},
        {1'b1, 8'hFF, 8'h01, 8'hFF}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          op_i = 1'b0;
    logic [DW-1:0] acc_i = '0, b_i = '0, c_i = '0;
    logic [DW-1:0] acc_o, b_o, c_o;
    logic          ov_o, cy_clr_o, done_o;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    muldiv_unit uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .acc_i(acc_i), .b_i(b_i), .c_i(c_i),
        .acc_o(acc_o), .b_o(b_o), .c_o(c_o),
        .ov_o(ov_o), .cy_clr_o(cy_clr_o), .done_o(done_o)
    );

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Reference model from the requirements: returns {acc, b, c, ov}.
    function automatic logic [24:0] model(input logic op, input logic [7:0] a,
                                          input logic [7:0] b, input logic [7:0] c);
        logic [23:0] p;
        logic [15:0] q, r;
        if (!op) begin
            p = {8'h00, a, c} * {16'h0000, b};
            return {p[15:8], p[23:16], p[7:0], (p[23:16] != 8'h00)};
        end else if (b == 8'h00) begin
            return {8'hFF, 8'h00, 8'hFF, 1'b1};
        end else begin
            q = {a, c} / {8'h00, b};
            r = {a, c} % {8'h00, b};
            return {q[15:8], r[7:0], q[7:0], (r == 16'h0000)};
        end
    endfunction

    // Issue one operation and check its timing and results (R1..R9).
    task automatic run_op(input logic op, input logic [7:0] a, input logic [7:0] b,
                          input logic [7:0] c, input logic inject);
        logic [24:0] e;
        e = model(op, a, b, c);
        @(negedge clk);
        start_i = 1'b1; op_i = op; acc_i = a; b_i = b; c_i = c;
        @(negedge clk);
        start_i = 1'b0; op_i = ~op; acc_i = ~a; b_i = b ^ 8'h5A; c_i = ~c;   // R1 late changes
        chk("R8", "done early", {31'd0, done_o}, 32'd0);
        for (int k = 1; k <= 6; k++) begin
            start_i = (inject && k == 2);                                  // R9 busy start
            @(negedge clk);
            start_i = 1'b0;
            if (k < 6) chk("R8", "done early", {31'd0, done_o}, 32'd0);
        end
        chk("R8", "done on 7th edge", {31'd0, done_o}, 32'd1);
        chk("R7", "carry clear with done", {31'd0, cy_clr_o}, 32'd1);
        chk(op ? "R4" : "R2", "acc", {24'd0, acc_o}, {24'd0, e[24:17]});
        chk(op ? (b == 0 ? "R6" : "R4") : "R2", "b", {24'd0, b_o}, {24'd0, e[16:9]});
        chk(op ? "R4" : "R1", "c", {24'd0, c_o}, {24'd0, e[8:1]});
        chk(op ? (b == 0 ? "R6" : "R5") : "R3", "ov", {31'd0, ov_o}, {31'd0, e[0]});
        @(negedge clk);
        chk("R8", "done single cycle", {31'd0, done_o}, 32'd0);
        chk("R7", "carry clear single", {31'd0, cy_clr_o}, 32'd0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            n_fail++;
            $display("FAIL watchdog expired");
            report();
            $finish;
        end
    end

    initial begin
        int extra;
        // R10: reset state.
        repeat (3) @(negedge clk);
        chk("R10", "acc reset", {24'd0, acc_o}, 32'd0);
        chk("R10", "b reset", {24'd0, b_o}, 32'd0);
        chk("R10", "c reset", {24'd0, c_o}, 32'd0);
        chk("R10", "ov reset", {31'd0, ov_o}, 32'd0);
        chk("R10", "done reset", {31'd0, done_o}, 32'd0);
        rst_n = 1'b1;

        // Table walk covering R1..R8.
        for (int i = 0; i < NV; i++)
            run_op(VECS[i][24], VECS[i][23:16], VECS[i][15:8], VECS[i][7:0], 1'b0);

        // R9: start pulse during a multiply and during a divide is ignored.
        run_op(1'b0, 8'h3C, 8'hA5, 8'h7E, 1'b1);
        run_op(1'b1, 8'hC3, 8'h0B, 8'h19, 1'b1);
        extra = 0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (done_o) extra++;
        end
        chk("R9", "no extra done", extra, 32'd0);

        // R10: reset in mid-operation abandons it and clears outputs.
        @(negedge clk);
        start_i = 1'b1; op_i = 1'b0; acc_i = 8'hFF; b_i = 8'hFF; c_i = 8'hFF;
        @(negedge clk);
        start_i = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R10", "acc cleared", {24'd0, acc_o}, 32'd0);
        chk("R10", "ov cleared", {31'd0, ov_o}, 32'd0);
        extra = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (done_o) extra++;
        end
        chk("R10", "abandoned op gives no done", extra, 32'd0);

        // Back-to-back operation after the reset still works.
        run_op(1'b1, 8'h01, 8'h03, 8'h00, 1'b0);

        report();
        $finish;
    end
endmodule